// File: doc/BRIEF.md
# Motion Detector Output State Controller

This block is the digital control logic behind a passive-infrared motion switch. An external window comparator, already synchronized to the block clock, supplies a detect flag. A trigger is a clock edge that sees both the detect flag and the enable input high. A trigger raises the active-high output for a hold time. Every hold time is followed by a lockout time. During lockout the output stays low and detect activity is ignored.

Both times are counted in clock cycles. They come from 24-bit count inputs, which are sampled only at the moment each period starts. A mode input selects between two behaviours. Retriggerable mode lets further detect activity extend the hold. One-shot mode ignores detect activity until the hold runs out. A synchronous active-low reset puts the block into lockout. This gives an inhibit interval after power-up, during which no trigger is accepted.

Top module: `mdet_top`

## Requirements
- R1: On a clock edge with rstN low, the output is low from that edge on, and the block enters lockout with the lock count sampled at that edge.
- R2: After rstN returns high, no trigger is accepted for max(lockCycles,1) clock edges. The edges counted start with the first edge that sees rstN high.
- R3: In the idle state, an edge that sees enable=1 and detect=1 drives outHigh high from that edge on.
- R4: While enable is low, detect cannot start an output pulse, and in either mode it cannot extend a running hold.
- R5: In one-shot mode (retrigMode=0), the output stays high for exactly max(holdCycles,1) cycles. A value of 0 behaves as 1.
- R6: In one-shot mode, detect activity during the hold has no effect on the hold length.
- R7: In retriggerable mode (retrigMode=1), each edge in hold that sees enable=1 and detect=1 reloads the full hold. The output falls max(holdCycles,1) edges after the last such edge.
- R8: When the output falls, lockout follows for max(lockCycles,1) cycles with the output low regardless of detect. Afterwards the block is idle and can trigger again. A lock value of 0 behaves as 1.
- R9: holdCycles and lockCycles are sampled only when a period starts or reloads. Changing them while a period runs does not alter that period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Synchronous reset, active low |
| detect | input | 1 | Synchronized motion flag from the window comparator |
| enable | input | 1 | Trigger enable; triggering is allowed only while high |
| retrigMode | input | 1 | 1 = retriggerable, 0 = one-shot |
| holdCycles | input | 24 | Hold length in clock cycles |
| lockCycles | input | 24 | Lockout length in clock cycles |
| outHigh | output | 1 | Active-high detector output |

## Verification
The bench aims at the first edges after reset is released, where a design without the power-up inhibit would fire at once. It drives a detect level held through the whole hold. In retriggerable mode the output must stay high, and in one-shot mode the pulse must still end exactly on time. A design that mixed up the modes would stretch or cut these pulses. It puts detect on the last hold edge and on the first lockout edge, where an off-by-one would extend the pulse or re-arm the output. Zero count values and counts changed in the middle of a period are also covered. Errors there would show up as pulses that never end or as hold lengths that jump mid-period.

// File: rtl/mdet_pkg.sv
package mdet_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_LOCK = 2'd2
  } mdetState_e;

  typedef struct packed {
    logic loadHold;
    logic loadLock;
    logic dec;
  } mdetStrb_t;
endpackage

// File: rtl/mdet_timer.sv
module mdet_timer
  import mdet_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  mdetStrb_t        strb,
  input  logic [CNT_W-1:0] holdCycles,
  input  logic [CNT_W-1:0] lockCycles,
  output logic             cntZero
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] holdLoad;
  logic [CNT_W-1:0] lockLoad;

  // Load value is period minus one; zero counts as a one-cycle period.
  assign holdLoad = (holdCycles == '0) ? '0 : holdCycles - ONE;
  assign lockLoad = (lockCycles == '0) ? '0 : lockCycles - ONE;

  always_ff @(posedge clk) begin
    if (strb.loadHold) begin
      cnt <= holdLoad;
    end else if (strb.loadLock) begin
      cnt <= lockLoad;
    end else if (strb.dec) begin
      cnt <= cnt - ONE;
    end
  end

  assign cntZero = (cnt == '0);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dec && !strb.loadHold && !strb.loadLock) |=> (cnt == $past(cnt) - ONE)); // R9

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    strb.dec |-> !cntZero); // R8
endmodule

// File: rtl/mdet_ctrl.sv
module mdet_ctrl
  import mdet_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      detect,
  input  logic      enable,
  input  logic      retrigMode,
  input  logic      cntZero,
  output mdetStrb_t strb,
  output logic      outHigh
);
  mdetState_e state;
  mdetState_e stateNxt;
  logic       trig;
  logic       retrig;

  assign trig   = enable && detect;
  assign retrig = retrigMode && trig;

  always_comb begin
    stateNxt      = state;
    strb.loadHold = 1'b0;
    strb.loadLock = 1'b0;
    strb.dec      = 1'b0;
    if (!rstN) begin
      stateNxt      = ST_LOCK;
      strb.loadLock = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (trig) begin
            stateNxt      = ST_HOLD;
            strb.loadHold = 1'b1;
          end
        end
        ST_HOLD: begin
          if (retrig) begin
            strb.loadHold = 1'b1;
          end else if (cntZero) begin
            stateNxt      = ST_LOCK;
            strb.loadLock = 1'b1;
          end else begin
            strb.dec = 1'b1;
          end
        end
        ST_LOCK: begin
          if (cntZero) begin
            stateNxt = ST_IDLE;
          end else begin
            strb.dec = 1'b1;
          end
        end
        default: begin
          stateNxt      = ST_LOCK;
          strb.loadLock = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    state <= stateNxt;
  end

  assign outHigh = (state == ST_HOLD);

  AST_IDLE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !enable) |=> (state == ST_IDLE)); // R4

  AST_ONESHOT_NO_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && !retrigMode) |-> !strb.loadHold); // R6

  AST_LOCK_BLOCKS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOCK) |=> (state != ST_HOLD)); // R8

  AST_RETRIG_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && retrigMode && enable && detect) |=> (state == ST_HOLD)); // R7
endmodule

// File: rtl/mdet_top.sv
module mdet_top
  import mdet_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             detect,
  input  logic             enable,
  input  logic             retrigMode,
  input  logic [CNT_W-1:0] holdCycles,
  input  logic [CNT_W-1:0] lockCycles,
  output logic             outHigh
);
  mdetStrb_t strb;
  logic      cntZero;

  mdet_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .detect     (detect),
    .enable     (enable),
    .retrigMode (retrigMode),
    .cntZero    (cntZero),
    .strb       (strb),
    .outHigh    (outHigh)
  );

  mdet_timer #(.CNT_W(CNT_W)) timer_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .holdCycles (holdCycles),
    .lockCycles (lockCycles),
    .cntZero    (cntZero)
  );

  AST_RESET_LOW: assert property (@(posedge clk)
    !rstN |=> !outHigh); // R1

  AST_RISE_NEEDS_TRIGGER: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outHigh) |-> $past(enable && detect)); // R3

  AST_FALL_STAYS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outHigh) |=> !outHigh); // R8
endmodule

// File: tb/mdet_top_tb_top.sv
module mdet_top_tb_top;
  localparam int CNT_W = 24;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             detect = 1'b0;
  logic             enable = 1'b0;
  logic             retrigMode = 1'b0;
  logic [CNT_W-1:0] holdCycles = 24'd4;
  logic [CNT_W-1:0] lockCycles = 24'd4;
  logic             outHigh;

  int    nChecks = 0;
  int    nFails = 0;
  bit    finished = 1'b0;
  bit    armed = 1'b0;
  string tag = "R1";

  // Reference model: 0 idle, 1 hold, 2 lockout; mRem = cycles left in period
  int mState = 2;
  int mRem = 4;

  always #2 clk = ~clk;

  mdet_top #(.CNT_W(CNT_W)) dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .detect     (detect),
    .enable     (enable),
    .retrigMode (retrigMode),
    .holdCycles (holdCycles),
    .lockCycles (lockCycles),
    .outHigh    (outHigh)
  );

  function automatic int atLeastOne(input logic [CNT_W-1:0] v);
    return (v == '0) ? 1 : int'(v);
  endfunction

  function automatic bit expOut(input int st);
    return st == 1;
  endfunction

  task automatic modelStep();
    if (!rstN) begin
      mState = 2;
      mRem   = atLeastOne(lockCycles);
    end else begin
      case (mState)
        0: if (enable && detect) begin
             mState = 1;
             mRem   = atLeastOne(holdCycles);
           end
        1: if (retrigMode && enable && detect) begin
             mRem = atLeastOne(holdCycles);
           end else if (mRem == 1) begin
             mState = 2;
             mRem   = atLeastOne(lockCycles);
           end else begin
             mRem = mRem - 1;
           end
        default: if (mRem == 1) mState = 0;
                 else mRem = mRem - 1;
      endcase
    end
  endtask

  // One clock: compare output at negedge, drive next inputs, advance model.
  task automatic cyc(input bit r, input bit d, input bit e, input bit m,
                     input logic [CNT_W-1:0] tx, input logic [CNT_W-1:0] ti);
    @(negedge clk);
    if (armed) begin
      nChecks++;
      if (outHigh !== expOut(mState)) begin
        nFails++;
        $display("FAIL %s: outHigh=%0b expected=%0b at %0t", tag, outHigh, expOut(mState), $time);
      end
    end
    rstN = r; detect = d; enable = e; retrigMode = m;
    holdCycles = tx; lockCycles = ti;
    modelStep();
    armed = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset forces output low
    tag = "R1";
    repeat (3) cyc(1'b0, 1'b1, 1'b1, 1'b1, 24'd6, 24'd5);
    // R2: detect held high right after release is blocked for lock count
    tag = "R2";
    repeat (12) cyc(1'b1, 1'b1, 1'b1, 1'b0, 24'd6, 24'd5);
    // R1: reset in the middle of a hold drops the output
    tag = "R1";
    cyc(1'b1, 1'b1, 1'b1, 1'b1, 24'd6, 24'd3);
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 24'd6, 24'd3);
    repeat (2) cyc(1'b1, 1'b0, 1'b1, 1'b1, 24'd6, 24'd3);
    // R4: enable low blocks triggering
    tag = "R4";
    repeat (20) cyc(1'b1, 1'b1, 1'b0, 1'b1, 24'd6, 24'd3);
    // R3 / R5: single pulse in one-shot mode
    tag = "R5";
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 24'd7, 24'd3);
    repeat (14) cyc(1'b1, 1'b0, 1'b1, 1'b0, 24'd7, 24'd3);
    // R6: detect held through hold in one-shot mode
    tag = "R6";
    repeat (25) cyc(1'b1, 1'b1, 1'b1, 1'b0, 24'd5, 24'd4);
    // R7: retrigger pulses spaced inside the hold
    tag = "R7";
    repeat (8) cyc(1'b1, 1'b0, 1'b1, 1'b1, 24'd5, 24'd4);
    for (int k = 0; k < 6; k++) begin
      cyc(1'b1, 1'b1, 1'b1, 1'b1, 24'd5, 24'd4);
      repeat (3) cyc(1'b1, 1'b0, 1'b1, 1'b1, 24'd5, 24'd4);
    end
    repeat (12) cyc(1'b1, 1'b0, 1'b1, 1'b1, 24'd5, 24'd4);
    // R4: enable low in hold does not extend in retrig mode
    tag = "R4";
    cyc(1'b1, 1'b1, 1'b1, 1'b1, 24'd4, 24'd2);
    repeat (10) cyc(1'b1, 1'b1, 1'b0, 1'b1, 24'd4, 24'd2);
    // R8: detect asserted around the fall edge and through lockout
    tag = "R8";
    repeat (4) cyc(1'b1, 1'b0, 1'b1, 1'b0, 24'd3, 24'd6);
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 24'd3, 24'd6);
    repeat (2) cyc(1'b1, 1'b0, 1'b1, 1'b0, 24'd3, 24'd6);
    repeat (10) cyc(1'b1, 1'b1, 1'b1, 1'b0, 24'd3, 24'd6);
    // R5 / R8: zero counts behave as one
    tag = "R5";
    repeat (12) cyc(1'b1, 1'b1, 1'b1, 1'b0, 24'd0, 24'd0);
    tag = "R8";
    repeat (12) cyc(1'b1, 1'b1, 1'b1, 1'b1, 24'd0, 24'd0);
    // R9: counts changed mid-period leave running period alone
    tag = "R9";
    repeat (6) cyc(1'b1, 1'b0, 1'b1, 1'b0, 24'd3, 24'd3);
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 24'd8, 24'd2);
    repeat (3) cyc(1'b1, 1'b0, 1'b1, 1'b0, 24'd2, 24'd9);
    repeat (20) cyc(1'b1, 1'b0, 1'b1, 1'b0, 24'd30, 24'd1);
    // Random mix covering R3, R5, R7, R8
    tag = "R3/R7 random";
    for (int i = 0; i < 4000; i++) begin
      logic [CNT_W-1:0] tx;
      logic [CNT_W-1:0] ti;
      bit r, d, e, m;
      tx = CNT_W'($urandom_range(0, 9));
      ti = CNT_W'($urandom_range(0, 9));
      r  = ($urandom_range(0, 199) != 0);
      d  = ($urandom_range(0, 3) == 0);
      e  = ($urandom_range(0, 9) != 0);
      m  = ((i / 300) % 2) == 1;
      cyc(r, d, e, m, tx, ti);
    end
    @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule